// File: doc/BRIEF.md
# Scalar Floating-Point Multiply Decode and Writeback Unit

This unit sits in the issue path of a vector/floating-point pipeline. Each cycle it examines a 32-bit instruction word and decides whether it encodes a scalar floating-point multiply. On a hit it extracts the two source register numbers and the destination register number. It selects half, single or double precision from a two-bit format field. It flags encodings that must be treated as undefined: a reserved format code, half precision when that feature is absent, or any hit when the base floating-point feature is absent.

The unit does no arithmetic. It presents the low element of each source, zero-extended to 64 bits, to an external multiplier. It then assembles the 128-bit value to be written to the destination register. The low element carries the multiplier result. The bits above it are either copied from the first source register (merge mode) or cleared. An optional output register stage, selected by a parameter, holds the decode results and the write value for one cycle, with a valid bit that follows the input valid.

Top module: `fp_mul_decode_wb`

## Requirements
- R1: A word is a hit only when (word & 32'hFF20FC00) == 32'h1E200800 and the input is valid. A word that is not a hit gives out_hit = 0, out_undef = 0, out_wr_en = 0, zero register numbers, zero element width and a zero write value.
- R2: On a legal hit, format field bits 23:22 select the element width: 00 gives 32, 01 gives 64 and 11 gives 16. The width is reported on out_elem_bits, and is 0 whenever out_wr_en is low.
- R3: A hit with format code 10 raises out_undef, keeps out_wr_en low and gives a zero write value.
- R4: A hit with format code 11 raises out_undef when feat_half_en is low. When feat_half_en is high it is a legal half-precision multiply.
- R5: Any hit raises out_undef when feat_fp_en is low, whatever the format.
- R6: On a hit, out_rm = word[20:16], out_rn = word[9:5] and out_rd = word[4:0].
- R7: In the same cycle as the word, mul_opnd_a and mul_opnd_b carry the low element of src1_reg and src2_low, zero-extended to 64 bits. The element is 16, 32 or 64 bits as the format field selects, and both operands are zero for format code 10. This holds whether or not the word is a hit.
- R8: When out_wr_en is high, the bits of out_wr_data below the element width equal the same bits of mul_result.
- R9: When out_wr_en is high, the bits of out_wr_data at and above the element width equal src1_reg when merge_upper is set, and are zero otherwise.
- R10: With OUT_STAGE = 1, every registered output reflects the inputs of the previous cycle, and out_vld equals the previous instr_vld. Reset clears out_vld and all registered outputs, and out_hit and out_wr_en are low whenever out_vld is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_vld | input | 1 | Instruction word is valid this cycle |
| instr_word | input | 32 | Instruction word to decode |
| feat_fp_en | input | 1 | Base floating-point feature present |
| feat_half_en | input | 1 | Half-precision feature present |
| merge_upper | input | 1 | Keep upper bits from first source instead of clearing |
| src1_reg | input | 128 | First source register value |
| src2_low | input | 64 | Low 64 bits of the second source register |
| mul_result | input | 64 | Product from the external multiplier, low-aligned |
| mul_opnd_a | output | 64 | First operand to the multiplier, zero-extended |
| mul_opnd_b | output | 64 | Second operand to the multiplier, zero-extended |
| out_vld | output | 1 | Result slot valid |
| out_hit | output | 1 | Word is a scalar multiply |
| out_undef | output | 1 | Word must be treated as undefined |
| out_wr_en | output | 1 | Destination write enable |
| out_elem_bits | output | 7 | Element width in bits (16, 32, 64, or 0) |
| out_rd | output | 5 | Destination register number |
| out_rn | output | 5 | First source register number |
| out_rm | output | 5 | Second source register number |
| out_wr_data | output | 128 | 128-bit destination write value |

## Verification
Undefined detection and result assembly act in the same cycle. A word that is a hit but undefined must suppress the write value that the merge logic would otherwise build from src1_reg and mul_result. Several scenarios provoke this collision: they set merge_upper with non-zero sources while presenting the reserved format code, half precision without its feature, and a missing base feature. Each one is judged by out_undef high, out_wr_en low and out_wr_data all zero. Random words with the fixed pattern in place mix legal and undefined cases, with merge_upper switching between them.

// File: rtl/fmd_pkg.sv
package fmd_pkg;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned REG_W    = 128;
    localparam int unsigned MAX_EW   = 64;
    localparam int unsigned IDX_W    = 5;
    localparam int unsigned EBITS_W  = 7;

    localparam logic [WORD_W-1:0] FIX_MASK = 32'hFF20_FC00;
    localparam logic [WORD_W-1:0] FIX_BITS = 32'h1E20_0800;

    typedef enum logic [1:0] {
        FMT_SINGLE = 2'b00,
        FMT_DOUBLE = 2'b01,
        FMT_RSVD   = 2'b10,
        FMT_HALF   = 2'b11
    } fmt_e;

    typedef struct packed {
        logic               hit;
        logic               undef;
        logic               wr_en;
        logic [EBITS_W-1:0] elem_bits;
        logic [IDX_W-1:0]   rd;
        logic [IDX_W-1:0]   rn;
        logic [IDX_W-1:0]   rm;
    } dec_t;

    typedef struct packed {
        logic             vld;
        dec_t             dec;
        logic [REG_W-1:0] data;
    } slot_t;

    // Width from the format code: 8 shifted by (code xor 2'b10).
    function automatic logic [EBITS_W-1:0] fmt_width(input fmt_e f);
        logic [1:0] sh;
        sh = 2'(f) ^ 2'b10;
        return EBITS_W'(8) << sh;
    endfunction

    function automatic logic [MAX_EW-1:0] low_mask(input fmt_e f);
        logic [MAX_EW-1:0] m;
        unique case (f)
            FMT_HALF:   m = 64'h0000_0000_0000_FFFF;
            FMT_SINGLE: m = 64'h0000_0000_FFFF_FFFF;
            FMT_DOUBLE: m = 64'hFFFF_FFFF_FFFF_FFFF;
            default:    m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/fmd_decoder.sv
module fmd_decoder
    import fmd_pkg::*;
(
    input  logic              vld,
    input  logic [WORD_W-1:0] word,
    input  logic              fp_en,
    input  logic              half_en,
    output fmt_e              fmt,
    output dec_t              dec
);
    logic match;
    logic bad_fmt;

    assign fmt   = fmt_e'(word[23:22]);
    assign match = vld && ((word & FIX_MASK) == FIX_BITS);

    always_comb begin
        unique case (fmt)
            FMT_RSVD: bad_fmt = 1'b1;
            FMT_HALF: bad_fmt = !half_en;
            default:  bad_fmt = 1'b0;
        endcase
    end

    always_comb begin
        dec           = '0;
        dec.hit       = match;
        dec.undef     = match && (!fp_en || bad_fmt);
        dec.wr_en     = match && fp_en && !bad_fmt;
        dec.elem_bits = dec.wr_en ? fmt_width(fmt) : '0;
        if (match) begin
            dec.rm = word[20:16];
            dec.rn = word[9:5];
            dec.rd = word[4:0];
        end
    end
endmodule

// File: rtl/fmd_operand_sel.sv
module fmd_operand_sel
    import fmd_pkg::*;
#(
    parameter int unsigned OPW = MAX_EW
) (
    input  fmt_e           fmt,
    input  logic [OPW-1:0] src,
    output logic [OPW-1:0] opnd
);
    localparam int unsigned LANES = OPW / 16;

    logic [MAX_EW-1:0] mask;
    assign mask = low_mask(fmt);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign opnd[l*16 +: 16] = src[l*16 +: 16] & mask[l*16 +: 16];
    end
endmodule

// File: rtl/fmd_result_merge.sv
module fmd_result_merge
    import fmd_pkg::*;
#(
    parameter int unsigned RW = REG_W,
    parameter int unsigned PW = MAX_EW
) (
    input  logic               wr_en,
    input  fmt_e               fmt,
    input  logic               merge,
    input  logic [RW-1:0]      src1,
    input  logic [PW-1:0]      prod,
    output logic [RW-1:0]      data
);
    localparam int unsigned CW = $clog2(RW) + 1;

    logic [CW-1:0] ew;
    assign ew = CW'(fmt_width(fmt));

    for (genvar g = 0; g < RW; g++) begin : g_bit
        logic in_elem;
        logic upper;
        assign in_elem = CW'(g) < ew;
        assign upper   = merge & src1[g];
        if (g < PW) begin : g_low
            assign data[g] = wr_en & (in_elem ? prod[g] : upper);
        end else begin : g_high
            assign data[g] = wr_en & !in_elem & upper;
        end
    end
endmodule

// File: rtl/fp_mul_decode_wb.sv
module fp_mul_decode_wb
    import fmd_pkg::*;
#(
    parameter bit OUT_STAGE = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         instr_vld,
    input  logic [31:0]  instr_word,
    input  logic         feat_fp_en,
    input  logic         feat_half_en,
    input  logic         merge_upper,
    input  logic [127:0] src1_reg,
    input  logic [63:0]  src2_low,
    input  logic [63:0]  mul_result,
    output logic [63:0]  mul_opnd_a,
    output logic [63:0]  mul_opnd_b,
    output logic         out_vld,
    output logic         out_hit,
    output logic         out_undef,
    output logic         out_wr_en,
    output logic [6:0]   out_elem_bits,
    output logic [4:0]   out_rd,
    output logic [4:0]   out_rn,
    output logic [4:0]   out_rm,
    output logic [127:0] out_wr_data
);
    fmt_e  fmt;
    dec_t  dec;
    slot_t now_s;
    slot_t out_s;

    fmd_decoder u_dec (
        .vld     (instr_vld),
        .word    (instr_word),
        .fp_en   (feat_fp_en),
        .half_en (feat_half_en),
        .fmt     (fmt),
        .dec     (dec)
    );

    fmd_operand_sel #(.OPW(MAX_EW)) u_opa (
        .fmt  (fmt),
        .src  (src1_reg[MAX_EW-1:0]),
        .opnd (mul_opnd_a)
    );

    fmd_operand_sel #(.OPW(MAX_EW)) u_opb (
        .fmt  (fmt),
        .src  (src2_low),
        .opnd (mul_opnd_b)
    );

    assign now_s.vld = instr_vld;
    assign now_s.dec = dec;

    fmd_result_merge #(.RW(REG_W), .PW(MAX_EW)) u_merge (
        .wr_en (dec.wr_en),
        .fmt   (fmt),
        .merge (merge_upper),
        .src1  (src1_reg),
        .prod  (mul_result),
        .data  (now_s.data)
    );

    if (OUT_STAGE) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) out_s <= '0;
            else     out_s <= now_s;
        end
    end else begin : g_comb
        assign out_s = now_s;
    end

    assign out_vld       = out_s.vld;
    assign out_hit       = out_s.dec.hit;
    assign out_undef     = out_s.dec.undef;
    assign out_wr_en     = out_s.dec.wr_en;
    assign out_elem_bits = out_s.dec.elem_bits;
    assign out_rd        = out_s.dec.rd;
    assign out_rn        = out_s.dec.rn;
    assign out_rm        = out_s.dec.rm;
    assign out_wr_data   = out_s.data;
endmodule

// File: rtl/fmd_checker.sv
module fmd_checker #(
    parameter bit OUT_STAGE = 1'b1
) (
    input logic         clk,
    input logic         rst,
    input logic         instr_vld,
    input logic [31:0]  instr_word,
    input logic         feat_fp_en,
    input logic [127:0] src1_reg,
    input logic [63:0]  mul_opnd_a,
    input logic         out_vld,
    input logic         out_hit,
    input logic         out_undef,
    input logic         out_wr_en,
    input logic [6:0]   out_elem_bits,
    input logic [127:0] out_wr_data
);
    assert_write_needs_hit_R1: assert property (@(posedge clk) disable iff (rst)
        out_wr_en |-> out_hit);

    assert_width_legal_R2: assert property (@(posedge clk) disable iff (rst)
        out_wr_en |-> (out_elem_bits == 7'd16 || out_elem_bits == 7'd32 || out_elem_bits == 7'd64));

    assert_undef_blocks_write_R3: assert property (@(posedge clk) disable iff (rst)
        out_undef |-> (!out_wr_en && out_wr_data == '0));

    assert_half_zext_R7: assert property (@(posedge clk) disable iff (rst)
        (instr_word[23:22] == 2'b11) |->
            (mul_opnd_a[63:16] == '0 && mul_opnd_a[15:0] == src1_reg[15:0]));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !out_vld |-> (!out_hit && !out_wr_en));

    if (OUT_STAGE) begin : g_seq
        assert_latency_R10: assert property (@(posedge clk) disable iff (rst)
            instr_vld |=> out_vld);

        assert_fp_gate_R5: assert property (@(posedge clk) disable iff (rst)
            (instr_vld && !feat_fp_en && ((instr_word & 32'hFF20FC00) == 32'h1E200800))
                |=> out_undef);
    end else begin : g_comb
        assert_fp_gate_R5: assert property (@(posedge clk) disable iff (rst)
            (out_hit && !feat_fp_en) |-> out_undef);
    end
endmodule

bind fp_mul_decode_wb fmd_checker #(.OUT_STAGE(OUT_STAGE)) u_fmd_chk (
    .clk           (clk),
    .rst           (rst),
    .instr_vld     (instr_vld),
    .instr_word    (instr_word),
    .feat_fp_en    (feat_fp_en),
    .src1_reg      (src1_reg),
    .mul_opnd_a    (mul_opnd_a),
    .out_vld       (out_vld),
    .out_hit       (out_hit),
    .out_undef     (out_undef),
    .out_wr_en     (out_wr_en),
    .out_elem_bits (out_elem_bits),
    .out_wr_data   (out_wr_data)
);

// File: tb/test_fp_mul_decode_wb.sv
`timescale 1ns/1ps
module test_fp_mul_decode_wb;

    typedef struct {
        logic         hit;
        logic         undef;
        logic         wr_en;
        logic [6:0]   ebits;
        logic [4:0]   rd;
        logic [4:0]   rn;
        logic [4:0]   rm;
        logic [127:0] data;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         instr_vld = 1'b0;
    logic [31:0]  instr_word = '0;
    logic         feat_fp_en = 1'b1;
    logic         feat_half_en = 1'b1;
    logic         merge_upper = 1'b0;
    logic [127:0] src1_reg = '0;
    logic [63:0]  src2_low = '0;
    logic [63:0]  mul_result = '0;
    logic [63:0]  mul_opnd_a, mul_opnd_b;
    logic         out_vld, out_hit, out_undef, out_wr_en;
    logic [6:0]   out_elem_bits;
    logic [4:0]   out_rd, out_rn, out_rm;
    logic [127:0] out_wr_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    exp_t sb[$];

    always #10 clk = ~clk;

    fp_mul_decode_wb #(.OUT_STAGE(1'b1)) i_fp_mul_decode_wb (
        .clk(clk), .rst(rst), .instr_vld(instr_vld), .instr_word(instr_word),
        .feat_fp_en(feat_fp_en), .feat_half_en(feat_half_en), .merge_upper(merge_upper),
        .src1_reg(src1_reg), .src2_low(src2_low), .mul_result(mul_result),
        .mul_opnd_a(mul_opnd_a), .mul_opnd_b(mul_opnd_b), .out_vld(out_vld),
        .out_hit(out_hit), .out_undef(out_undef), .out_wr_en(out_wr_en),
        .out_elem_bits(out_elem_bits), .out_rd(out_rd), .out_rn(out_rn), .out_rm(out_rm),
        .out_wr_data(out_wr_data)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic int width_of(input logic [1:0] f);
        case (f)
            2'b00:   return 32;
            2'b01:   return 64;
            2'b11:   return 16;
            default: return 0;
        endcase
    endfunction

    function automatic exp_t model(input logic [31:0] w);
        exp_t e;
        logic bad;
        int   wdt;
        e.hit = ((w & 32'hFF20FC00) == 32'h1E200800);
        bad   = !feat_fp_en || w[23:22] == 2'b10 || (w[23:22] == 2'b11 && !feat_half_en);
        e.undef = e.hit && bad;
        e.wr_en = e.hit && !bad;
        wdt     = width_of(w[23:22]);
        e.ebits = e.wr_en ? 7'(wdt) : 7'd0;
        e.rd = e.hit ? w[4:0]   : 5'd0;
        e.rn = e.hit ? w[9:5]   : 5'd0;
        e.rm = e.hit ? w[20:16] : 5'd0;
        e.data = '0;
        if (e.wr_en)
            for (int i = 0; i < 128; i++)
                e.data[i] = (i < wdt) ? mul_result[i] : (merge_upper & src1_reg[i]);
        return e;
    endfunction

    function automatic logic [63:0] zext(input logic [63:0] v, input logic [1:0] f);
        logic [63:0] r = '0;
        for (int i = 0; i < 64; i++) if (i < width_of(f)) r[i] = v[i];
        return r;
    endfunction

    function automatic logic [31:0] mk(input logic [1:0] f, input logic [4:0] rm,
                                       input logic [4:0] rn, input logic [4:0] rd);
        return 32'h1E200800 | {8'h0, f, 1'b0, rm, 6'h0, rn, rd};
    endfunction

    // Driver: applies one word at a negedge, checks the operand path (R7), queues the expectation.
    task automatic drive(input logic [31:0] w, input logic fp, input logic hf, input logic mg,
                         input logic [127:0] s1, input logic [63:0] s2, input logic [63:0] pr);
        @(negedge clk);
        instr_vld = 1'b1; instr_word = w; feat_fp_en = fp; feat_half_en = hf;
        merge_upper = mg; src1_reg = s1; src2_low = s2; mul_result = pr;
        #1;
        check(mul_opnd_a == zext(s1[63:0], w[23:22]), "R7", "operand a",
              {64'h0, mul_opnd_a}, {64'h0, zext(s1[63:0], w[23:22])});
        check(mul_opnd_b == zext(s2, w[23:22]), "R7", "operand b",
              {64'h0, mul_opnd_b}, {64'h0, zext(s2, w[23:22])});
        sb.push_back(model(w));
    endtask

    task automatic idle();
        @(negedge clk);
        instr_vld = 1'b0;
        instr_word = $urandom();
    endtask

    // Monitor: compares each valid result slot against the queue head.
    always @(posedge clk) begin
        #5;
        if (!rst && !done) begin
            if (out_vld) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R10", "unexpected out_vld", 128'(out_vld), 128'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(out_hit == e.hit, "R1", "hit", 128'(out_hit), 128'(e.hit));
                    check(out_undef == e.undef, "R3/R4/R5 undef", "undef", 128'(out_undef), 128'(e.undef));
                    check(out_wr_en == e.wr_en, "R3", "wr_en", 128'(out_wr_en), 128'(e.wr_en));
                    check(out_elem_bits == e.ebits, "R2", "elem bits", 128'(out_elem_bits), 128'(e.ebits));
                    check({out_rd, out_rn, out_rm} == {e.rd, e.rn, e.rm}, "R6", "reg numbers",
                          128'({out_rd, out_rn, out_rm}), 128'({e.rd, e.rn, e.rm}));
                    check(out_wr_data == e.data, "R8/R9 data", "write value", out_wr_data, e.data);
                end
            end else begin
                check(!out_hit && !out_wr_en, "R10", "idle slot quiet",
                      128'({out_hit, out_wr_en}), 128'd0);
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        check(1'b0, "R10", "watchdog expired", 128'd0, 128'd1);
        finish_run();
    end

    localparam logic [127:0] S1 = 128'hA5A5_1234_5678_9ABC_DEF0_1357_2468_ACE0;
    localparam logic [63:0]  S2 = 64'h0F0E_0D0C_0B0A_0908;
    localparam logic [63:0]  PR = 64'hCAFE_F00D_BEEF_7777;

    initial begin
        repeat (3) @(negedge clk);
        #5;
        check(!out_vld && !out_hit && !out_undef && out_wr_data == '0, "R10", "reset state",
              {out_vld, out_hit, out_undef, out_wr_data[124:0]}, 128'd0);
        @(negedge clk);
        rst = 1'b0;
        // R2 / R9: each legal format with and without merge
        drive(mk(2'b00, 5'd3, 5'd7, 5'd31), 1, 1, 1, S1, S2, PR);
        drive(mk(2'b00, 5'd3, 5'd7, 5'd31), 1, 1, 0, S1, S2, PR);
        drive(mk(2'b01, 5'd0, 5'd31, 5'd1), 1, 1, 1, S1, S2, PR);
        drive(mk(2'b01, 5'd9, 5'd2, 5'd0), 1, 1, 0, S1, S2, PR);
        drive(mk(2'b11, 5'd17, 5'd5, 5'd12), 1, 1, 1, S1, S2, PR);
        drive(mk(2'b11, 5'd17, 5'd5, 5'd12), 1, 1, 0, S1, S2, PR);
        idle();
        // R3: reserved format with merge pending
        drive(mk(2'b10, 5'd1, 5'd2, 5'd3), 1, 1, 1, S1, S2, PR);
        // R4: half precision without its feature
        drive(mk(2'b11, 5'd4, 5'd5, 5'd6), 1, 0, 1, S1, S2, PR);
        drive(mk(2'b00, 5'd4, 5'd5, 5'd6), 1, 0, 1, S1, S2, PR);
        // R5: base feature absent, every format
        for (int f = 0; f < 4; f++)
            drive(mk(2'(f), 5'd8, 5'd9, 5'd10), 0, 1, 1, S1, S2, PR);
        // R1: flip each fixed bit in turn
        for (int b = 0; b < 32; b++)
            if (32'hFF20FC00 & (32'h1 << b))
                drive(mk(2'b00, 5'd1, 5'd1, 5'd1) ^ (32'h1 << b), 1, 1, 1, S1, S2, PR);
        idle();
        idle();
        // random mix
        for (int n = 0; n < 400; n++) begin
            logic [31:0] w;
            w = ($urandom_range(0, 7) == 0) ? $urandom() : (($urandom() & ~32'hFF20FC00) | 32'h1E200800);
            drive(w, ($urandom_range(0, 5) != 0), $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
                  {$urandom(), $urandom(), $urandom(), $urandom()}, {$urandom(), $urandom()},
                  {$urandom(), $urandom()});
            if ($urandom_range(0, 4) == 0) idle();
        end
        idle();
        idle();
        idle();
        check(sb.size() == 0, "R10", "all results delivered", 128'(sb.size()), 128'd0);
        finish_run();
    end
endmodule